// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select and Clock Timing

This block is a single-channel SPI master. One transfer moves a 32-bit word out on `mosi` and collects a 32-bit word from `miso` under one active-low chip select. Every delay is counted in cycles of the block's own clock. The programmable delays are the chip-select setup before the first clock edge, the hold after the last edge and the deasserted gap before the next transfer. The high and low halves of the serial clock are set separately. All four clock polarity/phase modes are supported. Transmit and receive each have their own bit order and their own byte order.

A user applies the configuration and `tx_word`, then pulses `start` while `busy` is low. `busy` goes high on the next cycle. `done` pulses once when the transfer has finished, and `rx_word` is valid from that cycle onward. While the block is idle it reloads the configuration and the transmit word on every cycle. Once a transfer has started, both stay frozen until it ends.

Top module: `spi_timed_master`

## Requirements
- R1: `start` is seen on a clock edge while `busy` is low. On that edge `cs_n` falls and `busy` rises. The first `sck` edge follows `cfg_setup`+1 cycles later.
- R2: `cs_n` rises `cfg_hold`+1 cycles after the last (64th) `sck` edge.
- R3: After a transfer, `cs_n` stays high with `busy` still high for `cfg_gap`+1 cycles. The next `start` is taken one cycle after that at the earliest, so `cs_n` is high for at least `cfg_gap`+2 cycles between transfers.
- R4: `sck` rests at `cfg_cpol` when not shifting. It makes 32 pulses. Each high level lasts `cfg_sck_hi`+1 cycles and each low level lasts `cfg_sck_lo`+1 cycles.
- R5: When `cfg_cpha`=0, `mosi` shows serial bit i before leading edge i and changes on the trailing edges, and `miso` is taken on the leading edge. When `cfg_cpha`=1, `mosi` changes on the leading edges and `miso` is taken on the trailing edge.
- R6: Serial bit i (i=0..31, i=0 first) is `tx_word[8*B+j]`. B is i/8 when `cfg_tx_big_endian`=0 and 3-i/8 when it is 1. j is 7-(i mod 8) when `cfg_tx_lsb_first`=0 and i mod 8 when it is 1. During hold and the gap, `mosi` keeps serial bit 31.
- R7: The miso bit taken at serial step i goes to `rx_word[8*B+j]`, using the same mapping driven by `cfg_rx_big_endian` and `cfg_rx_lsb_first`. `rx_word` changes only in the cycle in which `done` is high.
- R8: `done` is high for exactly one cycle, the first cycle after the hold time, when `cs_n` has just risen. `busy` is high from the cycle after `start` up to the return to idle.
- R9: A `start` pulse while `busy` is high has no effect. Changes to the configuration inputs or to `tx_word` during a transfer do not alter it.
- R10: After reset, `cs_n`=1, `busy`=0, `done`=0, `rx_word`=0 and `sck`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | base clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | begin a transfer (taken only while idle) |
| tx_word | input | 32 | word to send |
| cfg_setup | input | CW | chip-select setup count |
| cfg_hold | input | CW | chip-select hold count |
| cfg_gap | input | CW | deasserted gap count |
| cfg_sck_hi | input | CW | sck high count |
| cfg_sck_lo | input | CW | sck low count |
| cfg_cpol | input | 1 | sck rest level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_tx_lsb_first | input | 1 | transmit bit order within a byte |
| cfg_rx_lsb_first | input | 1 | receive bit order within a byte |
| cfg_tx_big_endian | input | 1 | transmit byte order |
| cfg_rx_big_endian | input | 1 | receive byte order |
| miso | input | 1 | serial data in |
| busy | output | 1 | transfer in progress, including the gap |
| done | output | 1 | one-cycle completion pulse |
| rx_word | output | 32 | received word |
| cs_n | output | 1 | chip select, active low |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |

## Verification
The hardest thing to confirm from the ports is that `miso` is taken on exactly the right edge. A slow data line held steady across a whole bit would hide an off-by-one. To catch it, the bench's slave model drives the correct `miso` value only in the single cycle before the intended sampling edge and random values in every other cycle, so a capture one cycle early or late corrupts `rx_word`. A second transfer changes every configuration input and pulses `start` while the block is busy. A third pair runs back to back with a zero gap count, to reach the shortest legal deselect time.

// File: rtl/spi_timed_master.sv
module spi_timed_master #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   tx_word,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_gap,
  input  logic [CW-1:0] cfg_sck_hi,
  input  logic [CW-1:0] cfg_sck_lo,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_tx_lsb_first,
  input  logic          cfg_rx_lsb_first,
  input  logic          cfg_tx_big_endian,
  input  logic          cfg_rx_big_endian,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rx_word,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_t;

  st_t st;
  logic [CW-1:0] cnt, c_hold, c_gap, c_hi, c_lo;
  logic cpol, cpha, tx_lsb, rx_lsb, tx_big, rx_big, act;
  logic [31:0] tx_l, rx_acc;
  logic [4:0] bi, mi;

  function automatic logic [4:0] bitpos(logic [4:0] i, logic lsb, logic big);
    return {big ? ~i[4:3] : i[4:3], lsb ? i[2:0] : ~i[2:0]};
  endfunction

  wire [CW-1:0] len_act   = cpol ? c_lo : c_hi;
  wire [CW-1:0] len_inact = cpol ? c_hi : c_lo;
  wire [4:0]    nb        = bi + 5'd1;

  assign busy = (st != S_IDLE);
  assign cs_n = (st == S_IDLE) || (st == S_GAP);
  assign sck  = (st == S_SHIFT && act) ? ~cpol : cpol;
  assign mosi = tx_l[bitpos(mi, tx_lsb, tx_big)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      c_hold <= '0; c_gap <= '0; c_hi <= '0; c_lo <= '0;
      cpol <= 1'b0; cpha <= 1'b0;
      tx_lsb <= 1'b0; rx_lsb <= 1'b0; tx_big <= 1'b0; rx_big <= 1'b0;
      act <= 1'b0;
      tx_l <= '0; rx_acc <= '0; rx_word <= '0;
      bi <= '0; mi <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          c_hold <= cfg_hold; c_gap <= cfg_gap;
          c_hi <= cfg_sck_hi; c_lo <= cfg_sck_lo;
          cpol <= cfg_cpol; cpha <= cfg_cpha;
          tx_lsb <= cfg_tx_lsb_first; rx_lsb <= cfg_rx_lsb_first;
          tx_big <= cfg_tx_big_endian; rx_big <= cfg_rx_big_endian;
          tx_l <= tx_word;
          if (start) begin
            st <= S_SETUP;
            cnt <= cfg_setup;
            mi <= '0;
          end
        end
        S_SETUP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            st <= S_SHIFT;
            act <= 1'b1;
            bi <= '0;
            cnt <= len_act;
            if (!cpha) rx_acc[bitpos(5'd0, rx_lsb, rx_big)] <= miso;
          end
        end
        S_SHIFT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (act) begin
            act <= 1'b0;
            if (cpha) rx_acc[bitpos(bi, rx_lsb, rx_big)] <= miso;
            if (bi == 5'd31) begin
              st <= S_HOLD;
              cnt <= c_hold;
            end else begin
              cnt <= len_inact;
              if (!cpha) mi <= nb;
            end
          end else begin
            act <= 1'b1;
            bi <= nb;
            cnt <= len_act;
            if (cpha) mi <= nb;
            else rx_acc[bitpos(nb, rx_lsb, rx_big)] <= miso;
          end
        end
        S_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            st <= S_GAP;
            cnt <= c_gap;
            done <= 1'b1;
            rx_word <= rx_acc;
          end
        end
        S_GAP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            st <= S_IDLE;
            mi <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_timed_master_chk.sv
module spi_timed_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        cs_n,
  input logic        sck,
  input logic [31:0] rx_word
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_select_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_gap_sck_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && busy && $past(cs_n && busy)) |-> $stable(sck));

  assert_done_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && busy && $rose(cs_n)));

  assert_select_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $rose(busy));

  assert_rx_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> done);
endmodule

bind spi_timed_master spi_timed_master_chk u_chk (.*);

// File: tb/test_spi_timed_master.sv
`timescale 1ns/1ps
module test_spi_timed_master;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [31:0] tx_word = '0;
  logic [7:0] cfg_setup = '0, cfg_hold = '0, cfg_gap = '0, cfg_sck_hi = '0, cfg_sck_lo = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic cfg_tx_lsb_first = 1'b0, cfg_rx_lsb_first = 1'b0;
  logic cfg_tx_big_endian = 1'b0, cfg_rx_big_endian = 1'b0;
  logic busy, done, cs_n, sck, mosi;
  logic [31:0] rx_word;

  int checks = 0, errors = 0;
  bit cur_pol = 1'b0;

  typedef struct {bit cs_n; bit sck; bit mosi; bit miso; bit done; int seg;} ent_t;
  ent_t q[$];

  always #5 clk = ~clk;

  spi_timed_master i_spi_timed_master (.*);

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int spos(int i, bit lsb, bit big);
    int byte_sel = big ? 3 - i / 8 : i / 8;
    int bit_sel = lsb ? i % 8 : 7 - i % 8;
    return byte_sel * 8 + bit_sel;
  endfunction

  task automatic add(int n, int seg, bit cs, bit s, bit m, bit samp, bit sb, bit dn);
    for (int k = 0; k < n; k++) begin
      ent_t e;
      e.cs_n = cs; e.sck = s; e.mosi = m; e.seg = seg;
      e.miso = (samp && k == n - 1) ? sb : bit'($urandom_range(1));
      e.done = dn && k == 0;
      q.push_back(e);
    end
  endtask

  task automatic chk_idle();
    chk(cs_n == 1'b1, "R3", "idle cs_n", 32'(cs_n), 32'd1);
    chk(busy == 1'b0, "R8", "idle busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R8", "idle done", 32'(done), 32'd0);
    chk(sck == cur_pol, "R4", "idle sck", 32'(sck), 32'(cur_pol));
  endtask

  task automatic run_xfer(int su, int ho, int gp, int hi, int lo, bit pol, bit pha,
                          bit txl, bit txb, bit rxl, bit rxb,
                          logic [31:0] tx, logic [31:0] sl, bit poke);
    logic [31:0] rexp = '0;
    int la, li, k;
    string ctag;
    @(negedge clk);
    chk_idle();
    cfg_setup = 8'(su); cfg_hold = 8'(ho); cfg_gap = 8'(gp);
    cfg_sck_hi = 8'(hi); cfg_sck_lo = 8'(lo);
    cfg_cpol = pol; cfg_cpha = pha;
    cfg_tx_lsb_first = txl; cfg_tx_big_endian = txb;
    cfg_rx_lsb_first = rxl; cfg_rx_big_endian = rxb;
    tx_word = tx; start = 1'b1;
    cur_pol = pol;
    for (int i = 0; i < 32; i++) rexp[spos(i, rxl, rxb)] = sl[i];
    la = (pol ? lo : hi) + 1;
    li = (pol ? hi : lo) + 1;
    add(su + 1, 0, 1'b0, pol, tx[spos(0, txl, txb)], !pha, sl[0], 1'b0);
    for (int i = 0; i < 32; i++) begin
      add(la, 1, 1'b0, !pol, tx[spos(i, txl, txb)], pha, sl[i], 1'b0);
      if (i < 31)
        add(li, 2, 1'b0, pol, pha ? tx[spos(i, txl, txb)] : tx[spos(i + 1, txl, txb)],
            !pha, sl[i + 1], 1'b0);
    end
    add(ho + 1, 3, 1'b0, pol, tx[spos(31, txl, txb)], 1'b0, 1'b0, 1'b0);
    add(gp + 1, 4, 1'b1, pol, tx[spos(31, txl, txb)], 1'b0, 1'b0, 1'b1);
    k = 0;
    while (q.size() > 0) begin
      ent_t e;
      @(negedge clk);
      e = q.pop_front();
      ctag = (e.seg == 0) ? "R1" : (e.seg == 3) ? "R2" : (e.seg == 4) ? "R3" : "R4";
      chk(cs_n == e.cs_n, ctag, "cs_n", 32'(cs_n), 32'(e.cs_n));
      chk(sck == e.sck, poke ? "R9" : "R4", "sck", 32'(sck), 32'(e.sck));
      chk(mosi == e.mosi, poke ? "R9" : "R5 R6", "mosi", 32'(mosi), 32'(e.mosi));
      chk(busy == 1'b1, "R8", "busy", 32'(busy), 32'd1);
      chk(done == e.done, "R8", "done", 32'(done), 32'(e.done));
      if (e.done) chk(rx_word == rexp, "R7", "rx_word", rx_word, rexp);
      miso = e.miso;
      start = poke && (k == 4);
      if (poke && k == 1) begin
        cfg_setup = 8'hff; cfg_hold = 8'hff; cfg_gap = 8'hff;
        cfg_sck_hi = 8'h7; cfg_sck_lo = 8'h9;
        cfg_cpol = !pol; cfg_cpha = !pha;
        cfg_tx_lsb_first = !txl; cfg_tx_big_endian = !txb;
        cfg_rx_lsb_first = !rxl; cfg_rx_big_endian = !rxb;
        tx_word = ~tx;
      end
      k++;
    end
    start = 1'b0;
    if (poke) begin
      cfg_setup = 8'(su); cfg_hold = 8'(ho); cfg_gap = 8'(gp);
      cfg_sck_hi = 8'(hi); cfg_sck_lo = 8'(lo);
      cfg_cpol = pol; cfg_cpha = pha;
      cfg_tx_lsb_first = txl; cfg_tx_big_endian = txb;
      cfg_rx_lsb_first = rxl; cfg_rx_big_endian = rxb;
      tx_word = tx;
    end
  endtask

  task automatic idle_cycles(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk_idle();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(cs_n == 1'b1, "R10", "reset cs_n", 32'(cs_n), 32'd1);
    chk(busy == 1'b0, "R10", "reset busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);
    chk(rx_word == 32'd0, "R10", "reset rx_word", rx_word, 32'd0);
    chk(sck == 1'b0, "R10", "reset sck", 32'(sck), 32'd0);
    rst_n = 1'b1;
    idle_cycles(2);
    // mode 0, shortest timing, little endian, msb first
    run_xfer(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hA5C3_1E77, 32'h1234_5678, 0);
    idle_cycles(2);
    // mode 1, uneven phases, lsb-first transmit, big-endian receive
    run_xfer(3, 2, 1, 2, 0, 0, 1, 1, 0, 0, 1, 32'h0F0F_3C96, 32'hDEAD_BEEF, 0);
    idle_cycles(1);
    // mode 2, big-endian transmit, lsb-first receive
    run_xfer(1, 4, 2, 0, 3, 1, 0, 0, 1, 1, 0, 32'h8001_7FFE, 32'hC0FF_EE11, 0);
    idle_cycles(3);
    // mode 3 with start and config changes while busy (R9)
    run_xfer(2, 1, 3, 1, 2, 1, 1, 1, 1, 1, 1, 32'h5A5A_0FF0, 32'h9E37_79B9, 1);
    idle_cycles(2);
    // back to back with zero gap (R3)
    run_xfer(0, 1, 0, 1, 1, 0, 1, 0, 1, 1, 1, 32'hFFFF_0000, 32'h0000_FFFF, 0);
    run_xfer(1, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 32'h1357_9BDF, 32'h2468_ACE0, 0);
    idle_cycles(1);
    // largest counts
    run_xfer(255, 255, 255, 255, 255, 1, 0, 0, 0, 1, 1, 32'hCAFE_F00D, 32'h7654_3210, 0);
    idle_cycles(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule